// File: doc/BRIEF.md
# ISDN B-Channel Time-Slot Serial Port

This block is a four-wire serial port that carries one 8-bit sample in each direction per frame. The sample sits in one of the two bearer channels of a 2B+D frame. The far end supplies a bit clock and a sync pulse one bit-clock wide that opens each frame. A select input chooses the first or the second bearer slot. Data goes out on the rising edges of the bit clock and comes in on the falling edges. The transmit line is driven only during the eight bit times of the chosen slot. At all other times it floats.

The port stays inert until a mode input has stayed high across two sync pulses. Once armed, it takes the parallel transmit sample and the channel choice at each sync pulse. It shifts the sample out MSB first. It assembles the incoming bits into a parallel word and announces that word with a one-cycle valid strobe.

Top module: `tslot_port`

## Requirements
- R1: While `rstN` is low, `txOe`, `txBit` and `rxValid` are 0 and `rxSample` is 0.
- R2: The port becomes active only in the frame opened by the second sync pulse sampled while `modeIn` stays high on every rising edge. While the port is inactive, `txOe` and `rxValid` stay 0. A rising edge that samples `modeIn` low deactivates the port from the next cycle, and the two-sync count starts again.
- R3: With `chanSel` = 0 (first bearer slot) sampled at the sync edge, the 8 bits are driven MSB first on rising edges 1 through 8 after the sync edge, with `txOe` high exactly for those cycles.
- R4: With `chanSel` = 1 (second bearer slot) sampled at the sync edge, the 8 bits are driven MSB first on rising edges 11 through 18 after the sync edge.
- R5: `txSample` and `chanSel` are captured only at the sync edge. Changing them later in the frame has no effect on that frame's transmit bits, receive slot or slot timing.
- R6: For the first bearer slot, `rxIn` is sampled on falling edges 1 through 8 after the sync edge, with the first bit becoming the MSB of `rxSample`.
- R7: For the second bearer slot, `rxIn` is sampled on falling edges 11 through 18 after the sync edge, MSB first.
- R8: `rxValid` is high for exactly one cycle, following the rising edge after the eighth receive sample. `rxSample` takes the new word on that same edge and holds it until the next one.
- R9: Outside the selected slot, `txOe` is 0 and `txBit` is 0. This includes the unused bearer slot.
- R10: A sync pulse inside a slot ends it at once. `txOe` is 0 after that edge, the partial receive word produces no `rxValid`, and the new frame's slots are counted from this sync.
- R11: If no further sync arrives, the slot counter stops at its idle value and no further slot opens until the next sync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Bit clock; transmit on rising, receive on falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| syncIn | input | 1 | One-cycle frame sync pulse |
| modeIn | input | 1 | Mode qualifier; must stay high to arm the port |
| chanSel | input | 1 | Slot choice: 0 first bearer, 1 second bearer |
| txSample | input | 8 | Parallel sample to send in the next frame |
| rxIn | input | 1 | Serial receive line |
| txBit | output | 1 | Serial transmit data |
| txOe | output | 1 | Transmit driver enable; low means line floats |
| rxSample | output | 8 | Last received sample |
| rxValid | output | 1 | One-cycle strobe for a new `rxSample` |

## Verification
Embedded properties check on every cycle that a sync edge leaves the transmit driver off and that a low mode input silences both the driver and the valid strobe. They also check that the valid strobe never lasts two cycles and that the driver never stays on for more than eight consecutive bit times. The exact slot offsets, the MSB-first bit order and the capture of sample and channel at sync can only be shown by the bench. The same holds for the discarding of a word cut short by an early sync and for the two-sync arming sequence. The bench shows these by comparing against its frame-level reference model on every clock.

// File: rtl/tslot_pkg.sv
package tslot_pkg;

  // Strobes from control to datapath, valid for the current cycle.
  typedef struct packed {
    logic wordLoad;  // sync edge: capture parallel transmit word
    logic txDrive;   // this rising edge launches a slot bit
    logic rxTake;    // the coming falling edge samples a slot bit
    logic rxDone;    // eighth bit already sampled: publish word
  } slotCtrl_t;

endpackage

// File: rtl/tslot_ctrl.sv
module tslot_ctrl
  import tslot_pkg::*;
#(
  parameter int SAMPLE_W   = 8,
  parameter int CNT_W      = 5,
  parameter int B1_START   = 1,
  parameter int B2_START   = 11,
  parameter int MODE_SYNCS = 2
) (
  input  logic      bitClk,
  input  logic      rstN,
  input  logic      syncIn,
  input  logic      modeIn,
  input  logic      chanSel,
  output slotCtrl_t ctrl
);

  localparam int MODE_W = $clog2(MODE_SYNCS + 1);
  localparam logic [CNT_W-1:0]  POS_IDLE  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0]  POS_FIRST = CNT_W'(1);
  localparam logic [CNT_W-1:0]  B1_POS    = CNT_W'(B1_START);
  localparam logic [CNT_W-1:0]  B2_POS    = CNT_W'(B2_START);
  localparam logic [CNT_W-1:0]  SLOT_SPAN = CNT_W'(SAMPLE_W - 1);
  localparam logic [MODE_W-1:0] MODE_FULL = MODE_W'(MODE_SYNCS);
  localparam logic [MODE_W-1:0] MODE_ARM  = MODE_W'(MODE_SYNCS - 1);

  logic [CNT_W-1:0]  slotPos;
  logic [CNT_W-1:0]  slotStart;
  logic [CNT_W-1:0]  slotEnd;
  logic [MODE_W-1:0] modeCnt;
  logic              chanLat;
  logic              portEn;
  logic              inWindow;

  // Position inside the frame: 1 on the first edge after sync.
  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      slotPos <= POS_IDLE;
      chanLat <= 1'b0;
    end else if (syncIn) begin
      slotPos <= POS_FIRST;
      chanLat <= chanSel;
    end else if (slotPos != POS_IDLE) begin
      slotPos <= slotPos + 1'b1;
    end
  end

  // Mode qualifier: count sync pulses seen while modeIn stays high.
  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      modeCnt <= '0;
      portEn  <= 1'b0;
    end else if (!modeIn) begin
      modeCnt <= '0;
      portEn  <= 1'b0;
    end else if (syncIn) begin
      if (modeCnt >= MODE_ARM) portEn <= 1'b1;
      if (modeCnt < MODE_FULL) modeCnt <= modeCnt + 1'b1;
    end
  end

  assign slotStart = chanLat ? B2_POS : B1_POS;
  assign slotEnd   = slotStart + SLOT_SPAN;
  assign inWindow  = portEn && (slotPos >= slotStart) && (slotPos <= slotEnd);

  always_comb begin
    ctrl          = '0;
    ctrl.wordLoad = syncIn;
    ctrl.txDrive  = inWindow && modeIn && !syncIn;
    ctrl.rxTake   = inWindow;
    ctrl.rxDone   = portEn && modeIn && (slotPos == slotEnd);
  end

  // Run length of consecutive drive cycles, for the slot-length check.
  logic [CNT_W-1:0] driveRun;
  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN)             driveRun <= '0;
    else if (ctrl.txDrive) driveRun <= driveRun + 1'b1;
    else                   driveRun <= '0;
  end

  p_slot_len_r3: assert property (@(posedge bitClk) disable iff (!rstN)
    driveRun <= CNT_W'(SAMPLE_W));

endmodule

// File: rtl/tslot_datapath.sv
module tslot_datapath
  import tslot_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                bitClk,
  input  logic                rstN,
  input  slotCtrl_t           ctrl,
  input  logic [SAMPLE_W-1:0] txSample,
  input  logic                rxIn,
  output logic                txBit,
  output logic                txOe,
  output logic [SAMPLE_W-1:0] rxSample,
  output logic                rxValid
);

  localparam int MSB = SAMPLE_W - 1;

  logic [SAMPLE_W-1:0] txShReg;
  logic [SAMPLE_W-1:0] rxShReg;

  // Transmit: load at sync, shift out MSB first on drive edges.
  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      txShReg <= '0;
      txBit   <= 1'b0;
      txOe    <= 1'b0;
    end else begin
      txOe  <= ctrl.txDrive;
      txBit <= ctrl.txDrive ? txShReg[MSB] : 1'b0;
      if (ctrl.wordLoad)     txShReg <= txSample;
      else if (ctrl.txDrive) txShReg <= {txShReg[MSB-1:0], 1'b0};
    end
  end

  // Receive: sample on falling edges inside the slot.
  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN)            rxShReg <= '0;
    else if (ctrl.rxTake) rxShReg <= {rxShReg[MSB-1:0], rxIn};
  end

  // Publish the assembled word on the rising edge after the last bit.
  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      rxSample <= '0;
      rxValid  <= 1'b0;
    end else begin
      rxValid <= ctrl.rxDone;
      if (ctrl.rxDone) rxSample <= rxShReg;
    end
  end

  p_valid_pulse_r8: assert property (@(posedge bitClk) disable iff (!rstN)
    rxValid |=> !rxValid);

endmodule

// File: rtl/tslot_port.sv
module tslot_port
  import tslot_pkg::*;
#(
  parameter int SAMPLE_W   = 8,
  parameter int CNT_W      = 5,
  parameter int B1_START   = 1,
  parameter int B2_START   = 11,
  parameter int MODE_SYNCS = 2
) (
  input  logic                bitClk,
  input  logic                rstN,
  input  logic                syncIn,
  input  logic                modeIn,
  input  logic                chanSel,
  input  logic [SAMPLE_W-1:0] txSample,
  input  logic                rxIn,
  output logic                txBit,
  output logic                txOe,
  output logic [SAMPLE_W-1:0] rxSample,
  output logic                rxValid
);

  slotCtrl_t ctrl;

  tslot_ctrl #(
    .SAMPLE_W  (SAMPLE_W),
    .CNT_W     (CNT_W),
    .B1_START  (B1_START),
    .B2_START  (B2_START),
    .MODE_SYNCS(MODE_SYNCS)
  ) ctrl_i (
    .bitClk (bitClk),
    .rstN   (rstN),
    .syncIn (syncIn),
    .modeIn (modeIn),
    .chanSel(chanSel),
    .ctrl   (ctrl)
  );

  tslot_datapath #(
    .SAMPLE_W(SAMPLE_W)
  ) dp_i (
    .bitClk  (bitClk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .txSample(txSample),
    .rxIn    (rxIn),
    .txBit   (txBit),
    .txOe    (txOe),
    .rxSample(rxSample),
    .rxValid (rxValid)
  );

  p_sync_quiet_r10: assert property (@(posedge bitClk) disable iff (!rstN)
    syncIn |=> !txOe);

  p_mode_off_r2: assert property (@(posedge bitClk) disable iff (!rstN)
    !modeIn |=> (!txOe && !rxValid));

endmodule

// File: tb/tslot_port_tb_top.sv
`timescale 1ns/1ps
module tslot_port_tb_top;

  logic       bitClk = 1'b0;
  logic       rstN   = 1'b0;
  logic       syncIn = 1'b0;
  logic       modeIn = 1'b0;
  logic       chanSel = 1'b0;
  logic [7:0] txSample = 8'h00;
  logic       rxIn = 1'b0;
  logic       txBit, txOe, rxValid;
  logic [7:0] rxSample;

  always #4 bitClk = ~bitClk;  // 125 MHz

  tslot_port dut_i (
    .bitClk(bitClk), .rstN(rstN), .syncIn(syncIn), .modeIn(modeIn),
    .chanSel(chanSel), .txSample(txSample), .rxIn(rxIn),
    .txBit(txBit), .txOe(txOe), .rxSample(rxSample), .rxValid(rxValid)
  );

  int vecCount  = 0;
  int failCount = 0;
  string txTag = "R1";
  string rxTag = "R1";
  bit done = 0;

  // ---------------- behavioural reference model ----------------
  int         mPos = 31;
  int         mModeCnt = 0;
  bit         mEn = 0;
  bit         mChan = 0;
  logic [7:0] mWord = 0;
  bit         mTxOe = 0, mTxBit = 0, mRxValid = 0;
  logic [7:0] mRxOut = 0;
  bit         mBits [8];

  function automatic int slotBegin(bit ch);
    return ch ? 11 : 1;
  endfunction

  always @(negedge bitClk) begin
    if (rstN && mEn && mPos >= slotBegin(mChan) && mPos <= slotBegin(mChan) + 7)
      mBits[mPos - slotBegin(mChan)] = rxIn;
  end

  always @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      mPos = 31; mModeCnt = 0; mEn = 0; mChan = 0; mWord = 0;
      mTxOe = 0; mTxBit = 0; mRxValid = 0; mRxOut = 0;
    end else begin
      int st;
      bit inw;
      st  = slotBegin(mChan);
      inw = mEn && mPos >= st && mPos <= st + 7;
      mTxOe  = inw && modeIn && !syncIn;
      mTxBit = mTxOe ? mWord[7 - (mPos - st)] : 1'b0;
      mRxValid = mEn && modeIn && (mPos == st + 7);
      if (mRxValid)
        for (int k = 0; k < 8; k++) mRxOut[7 - k] = mBits[k];
      if (!modeIn) begin
        mModeCnt = 0; mEn = 0;
      end else if (syncIn) begin
        if (mModeCnt >= 1) mEn = 1;
        if (mModeCnt < 2) mModeCnt++;
      end
      if (syncIn) begin
        mPos = 1; mChan = chanSel; mWord = txSample;
      end else if (mPos < 31) begin
        mPos++;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic checkOne(string tag, string what, logic [7:0] act, logic [7:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    checkOne(txTag, "txOe", {7'b0, txOe}, {7'b0, mTxOe});
    checkOne(mTxOe ? txTag : "R9", "txBit", {7'b0, txBit}, {7'b0, mTxBit});
    checkOne("R8", "rxValid", {7'b0, rxValid}, {7'b0, mRxValid});
    checkOne(rxTag, "rxSample", rxSample, mRxOut);
  endtask

  task automatic tick();
    @(posedge bitClk);
    #6;
    compareAll();
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  endtask

  // One frame: sync cycle then len-1 quiet cycles. The channel and word
  // change at cycle chgAt (if >= 0) to probe the sync-time capture.
  task automatic runFrame(int len, bit ch, logic [7:0] tw, logic [7:0] rw, int chgAt);
    int st;
    st = slotBegin(ch);
    for (int j = 0; j < len; j++) begin
      syncIn = (j == 0);
      if (j == 0) begin chanSel = ch; txSample = tw; end
      if (j == chgAt) begin chanSel = ~ch; txSample = ~tw; end
      if (j + 1 >= st && j + 1 <= st + 7) rxIn = rw[7 - (j + 1 - st)];
      else rxIn = 1'($urandom);
      tick();
    end
  endtask

  initial begin
    repeat (150000) @(posedge bitClk);
    failCount++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    // R1: reset values
    txTag = "R1"; rxTag = "R1";
    for (int i = 0; i < 3; i++) begin
      #0; @(posedge bitClk); #6; compareAll();
    end
    rstN = 1'b1;

    // R2: mode low, then arming over two syncs
    txTag = "R2"; rxTag = "R2";
    modeIn = 0;
    runFrame(32, 0, 8'hA5, 8'h5A, -1);
    modeIn = 1;
    runFrame(32, 0, 8'hC3, 8'h81, -1);   // first sync: still inactive
    runFrame(32, 0, 8'h96, 8'h69, -1);   // second sync: active

    // R3 / R6: first bearer slot
    txTag = "R3"; rxTag = "R6";
    runFrame(32, 0, 8'h3C, 8'hE1, -1);
    runFrame(32, 0, 8'h01, 8'h80, -1);
    for (int f = 0; f < 4; f++)
      runFrame(32, 0, 8'($urandom), 8'($urandom), -1);

    // R4 / R7: second bearer slot
    txTag = "R4"; rxTag = "R7";
    runFrame(32, 1, 8'hF0, 8'h0F, -1);
    runFrame(32, 1, 8'h80, 8'h01, -1);
    for (int f = 0; f < 4; f++)
      runFrame(32, 1, 8'($urandom), 8'($urandom), -1);

    // R5: change word and channel after the sync edge
    txTag = "R5"; rxTag = "R5";
    runFrame(32, 0, 8'hB4, 8'h4B, 3);
    runFrame(32, 1, 8'h6D, 8'hD6, 12);
    runFrame(32, 0, 8'h2E, 8'hE2, 1);

    // R10: sync arriving inside a slot
    txTag = "R10"; rxTag = "R10";
    runFrame(5, 0, 8'hFF, 8'hFF, -1);
    runFrame(14, 1, 8'hAA, 8'h55, -1);
    runFrame(8, 0, 8'hCC, 8'h33, -1);
    runFrame(32, 0, 8'h99, 8'h66, -1);

    // R11: long gap without sync
    txTag = "R11"; rxTag = "R11";
    runFrame(70, 1, 8'h5C, 8'hC5, -1);
    runFrame(32, 0, 8'h17, 8'h71, -1);

    // R2: drop mode inside a slot, then re-arm
    txTag = "R2"; rxTag = "R2";
    syncIn = 1; chanSel = 0; txSample = 8'hE7; tick();
    syncIn = 0;
    for (int i = 0; i < 4; i++) tick();
    modeIn = 0;
    for (int i = 0; i < 30; i++) tick();
    modeIn = 1;
    runFrame(32, 0, 8'h42, 8'h24, -1);
    runFrame(32, 1, 8'hBD, 8'hDB, -1);
    runFrame(32, 1, 8'h11, 8'h88, -1);

    report();
  end

endmodule